// File: doc/BRIEF.md
# Dual-Channel Pointer-Addressed Serial Register File

This block is the byte-wide host side of a two-channel serial controller. Each channel owns sixteen write registers and sixteen read registers. A host reaches them through two ports per channel: a control port that goes through an indirect register pointer, and a data port. Two address bits pick the channel and the port. A strap input swaps which of the two bits picks which.

The pointer is handled by a two-state machine in each channel. In `PS_BASE` the pointer is zero, and a control write is taken as a command. The *select* transition loads a pointer, and the channel moves to `PS_ARMED` if that pointer is nonzero. In `PS_ARMED` the next control write goes to the register at the pointer. That write takes the *return* transition back to `PS_BASE`. The exception is a reset command written to register 9: it takes the *reset-hold* transition and keeps the pointer. Any control read takes the *read-clear* transition to `PS_BASE`. A reset of the channel takes the *reset-clear* transition.

Soft and hard resets restore registers through per-register bit masks rather than clearing them. Data-port accesses update status bits and emit a transmit strobe or a receive-pop strobe. Each channel also keeps a registered clock divisor derived from its line and time-constant registers.

Top module: `sreg_dual_regfile`

## Requirements
- R1: After power-up reset, every read register of both channels reads 0x00, except read register 0, which reads 0x04 (transmit empty). Both divisors read 4, and no strobe is active.
- R2: With `addr_swap` low, `addr[0]` selects the data port (1) or control port (0), and `addr[1]` selects the channel. With `addr_swap` high, the roles of the two bits are exchanged.
- R3: A control write while the pointer is 0 loads `wdata[2:0]` as the pointer. If `wdata[5:3]` equals 3'b001, it also sets pointer bit 3, which reaches registers 8 to 15.
- R4: A control write with a nonzero pointer stores the byte and returns the pointer to 0. A control read returns the read register at the pointer and also returns the pointer to 0.
- R5: A write of register 9 with `wdata[7:6]` nonzero issues a reset. The code 01 soft-resets channel 0, 10 soft-resets channel 1, and 11 hard-resets both channels. The pointer of the channel doing the write is left unchanged, unless that channel is itself reset. Every channel that is reset has its pointer cleared.
- R6: A soft reset makes these changes:
  - register 15 becomes 0xF8;
  - register 5 is masked with 0x61, which drops transmit enable (bit 3);
  - register 3 loses receive enable (bit 0);
  - register 4 gains bit 2;
  - register 1 is masked with 0x24, register 10 with 0x60, and register 9 with 0xDF;
  - register 14 is masked with 0xC3 and then gains 0x20;
  - register 0 is cleared.
  On the read side, read register 0 keeps only the bits in 0xB8 and then gains 0x44. Read register 1 keeps bit 0 and gains 0x06. Read register 3 is cleared, and read register 10 keeps only bit 6.
- R7: A hard reset applies the soft reset and then makes these further changes:
  - register 9 keeps only the bits in 0x03 and gains 0xC0;
  - register 10 is cleared;
  - register 11 becomes 0x08;
  - register 14 keeps only the bits in 0xC0 and gains 0x30.
  Read registers 12 and 13 are not changed.
- R8: Writing register 3 with bit 4 set sets bit 4 (sync/hunt) of read register 0. A write to register 12 or 13 is copied into read register 12 or 13.
- R9: A data-port write sets bit 2 of read register 0 and bit 0 of read register 1. If bit 3 of register 5 is set, it also pulses `tx_valid` for that channel for one cycle, in the cycle after the write, with the byte on `tx_byte`. Otherwise no strobe is produced.
- R10: A `rx_push` is accepted only when bit 0 of register 3 is set and bit 0 of read register 0 is clear. An accepted push latches the byte and sets read register 0 bit 0. A data-port read returns the latched byte, clears bit 0, and pulses `rx_pop` for one cycle in the next cycle.
- R11: The divisor is 2 × (time constant + 2) × P. The time constant is {register 13, register 12}. P is 1, 16, 32 or 64 for register 4 bits [7:6] = 00, 01, 10 or 11. The divisor register takes the new value on the second clock edge after a write to register 4, 5, 12 or 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| addr_swap | input | 1 | Strap that exchanges the roles of the two address bits |
| acc_wr | input | 1 | Host write strobe, one byte per cycle |
| acc_rd | input | 1 | Host read strobe, one byte per cycle |
| addr | input | 2 | Channel and port select |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid in the cycle of `acc_rd` |
| rx_push | input | 2 | Per-channel received-byte strobe |
| rx_byte | input | 16 | Received byte per channel, channel 0 in bits [7:0] |
| tx_valid | output | 2 | Per-channel transmit strobe |
| tx_byte | output | 8 | Byte that goes with `tx_valid` |
| rx_pop | output | 2 | Per-channel strobe that the receive byte has been taken |
| baud_div | output | 48 | Per-channel clock divisor, channel 0 in bits [23:0] |

## Verification
A pointer machine left in the wrong state shows up at the very next control read. That read returns a different register, for example the mirrored time constant where transmit-empty status should appear. A wrong reset mask shows up within a few accesses: status bytes read back wrong, a receive push is accepted when it should be dropped, or a transmit strobe that should be blocked appears. The scoreboard catches a missing or extra strobe on the cycle after the data-port access. A divisor that is late or early differs from the expected value one cycle after the write.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_REG    = 16;
    localparam int PTR_W      = $clog2(NUM_REG);
    localparam int NUM_CH     = 2;
    localparam int TC_W       = 2 * BYTE_W;
    localparam int PRE_SH_MAX = 6;
    localparam int DIV_W      = TC_W + 2 + PRE_SH_MAX;

    localparam logic [PTR_W-1:0] IX_STAT   = 4'd0;
    localparam logic [PTR_W-1:0] IX_SENT   = 4'd1;
    localparam logic [PTR_W-1:0] IX_RXCFG  = 4'd3;
    localparam logic [PTR_W-1:0] IX_LINE   = 4'd4;
    localparam logic [PTR_W-1:0] IX_TXCFG  = 4'd5;
    localparam logic [PTR_W-1:0] IX_RSTCTL = 4'd9;
    localparam logic [PTR_W-1:0] IX_CLKSRC = 4'd11;
    localparam logic [PTR_W-1:0] IX_TCLO   = 4'd12;
    localparam logic [PTR_W-1:0] IX_TCHI   = 4'd13;
    localparam logic [PTR_W-1:0] IX_EXTEN  = 4'd15;

    localparam logic [2:0] CMD_UPPER = 3'b001;

    typedef enum logic [1:0] {
        RST_NONE = 2'b00,
        RST_CH0  = 2'b01,
        RST_CH1  = 2'b10,
        RST_BOTH = 2'b11
    } rst_code_e;

    typedef enum logic {
        PS_BASE,
        PS_ARMED
    } ptr_state_e;

    function automatic logic [BYTE_W-1:0] soft_wr_val(input logic [PTR_W-1:0] idx,
                                                      input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        case (idx)
            4'd0:    r = '0;
            4'd1:    r = v & 8'h24;
            4'd3:    r = v & 8'hFE;
            4'd4:    r = v | 8'h04;
            4'd5:    r = v & 8'h61;
            4'd9:    r = v & 8'hDF;
            4'd10:   r = v & 8'h60;
            4'd14:   r = (v & 8'hC3) | 8'h20;
            4'd15:   r = 8'hF8;
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] hard_wr_val(input logic [PTR_W-1:0] idx,
                                                      input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] s;
        logic [BYTE_W-1:0] r;
        s = soft_wr_val(idx, v);
        case (idx)
            4'd9:    r = (s & 8'h03) | 8'hC0;
            4'd10:   r = '0;
            4'd11:   r = 8'h08;
            4'd14:   r = (s & 8'hC0) | 8'h30;
            default: r = s;
        endcase
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] reset_rr_val(input logic [PTR_W-1:0] idx,
                                                       input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        case (idx)
            4'd0:    r = (v & 8'hB8) | 8'h44;
            4'd1:    r = (v & 8'h01) | 8'h06;
            4'd3:    r = '0;
            4'd10:   r = v & 8'h40;
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
    import sreg_pkg::*;
(
    input  logic       addr_swap,
    input  logic [1:0] addr,
    output logic       ch_sel,
    output logic       is_data
);

    always_comb begin
        if (addr_swap) begin
            is_data = addr[1];
            ch_sel  = addr[0];
        end else begin
            is_data = addr[0];
            ch_sel  = addr[1];
        end
    end

endmodule

// File: rtl/sreg_baud.sv
module sreg_baud
    import sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [1:0]       mode,
    input  logic [TC_W-1:0]  tc,
    output logic [DIV_W-1:0] div
);

    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(4);

    logic             upd_q;
    logic [DIV_W-1:0] base;
    logic [DIV_W-1:0] calc;

    always_comb begin
        base = (DIV_W'(tc) + DIV_W'(2)) << 1;
        unique case (mode)
            2'b00: calc = base;
            2'b01: calc = base << 4;
            2'b10: calc = base << 5;
            2'b11: calc = base << 6;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
            div   <= DIV_RST;
        end else begin
            upd_q <= upd;
            if (upd_q) begin
                div <= calc;
            end
        end
    end

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_RST); // R11

    AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |=> $stable(div)); // R11

endmodule

// File: rtl/sreg_chan.sv
module sreg_chan
    import sreg_pkg::*;
#(
    parameter int CH_ID = 0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              is_data,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              soft_rst,
    input  logic              hard_rst,
    output rst_code_e         rst_req,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              tx_fire,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              rx_pop,
    output logic [DIV_W-1:0]  div
);

    logic [BYTE_W-1:0] wr_q [NUM_REG];
    logic [BYTE_W-1:0] rr_q [NUM_REG];
    logic [BYTE_W-1:0] rx_q;
    logic [PTR_W-1:0]  ptr_q, ptr_d;
    ptr_state_e        state_q, state_d;

    logic ctrl_wr, ctrl_rd, data_wr, data_rd;
    logic self_rst, reg_store, tc_upd;

    assign ctrl_wr  = sel && acc_wr && !is_data;
    assign ctrl_rd  = sel && acc_rd && !is_data;
    assign data_wr  = sel && acc_wr && is_data;
    assign data_rd  = sel && acc_rd && is_data;
    assign self_rst = soft_rst || hard_rst;

    always_comb begin
        if (ctrl_wr && state_q == PS_ARMED && ptr_q == IX_RSTCTL) begin
            rst_req = rst_code_e'(wdata[7:6]);
        end else begin
            rst_req = RST_NONE;
        end
    end

    assign reg_store = ctrl_wr && state_q == PS_ARMED && rst_req == RST_NONE;
    assign tc_upd    = reg_store && (ptr_q == IX_LINE || ptr_q == IX_TXCFG ||
                                     ptr_q == IX_TCLO || ptr_q == IX_TCHI);

    // pointer machine: next state
    always_comb begin
        ptr_d   = ptr_q;
        state_d = state_q;
        if (self_rst) begin
            ptr_d   = '0;
            state_d = PS_BASE;
        end else if (ctrl_rd) begin
            ptr_d   = '0;
            state_d = PS_BASE;
        end else if (ctrl_wr) begin
            unique case (state_q)
                PS_BASE: begin
                    ptr_d   = {wdata[5:3] == CMD_UPPER, wdata[2:0]};
                    state_d = (ptr_d != '0) ? PS_ARMED : PS_BASE;
                end
                PS_ARMED: begin
                    if (rst_req == RST_NONE) begin
                        ptr_d   = '0;
                        state_d = PS_BASE;
                    end
                end
            endcase
        end
    end

    // pointer machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_BASE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REG; i++) begin
                wr_q[i] <= '0;
                rr_q[i] <= '0;
            end
            rr_q[IX_STAT] <= 8'h04;
            rx_q          <= '0;
        end else if (hard_rst) begin
            for (int i = 0; i < NUM_REG; i++) begin
                wr_q[i] <= hard_wr_val(PTR_W'(i), wr_q[i]);
                rr_q[i] <= reset_rr_val(PTR_W'(i), rr_q[i]);
            end
            rx_q <= '0;
        end else if (soft_rst) begin
            for (int i = 0; i < NUM_REG; i++) begin
                wr_q[i] <= soft_wr_val(PTR_W'(i), wr_q[i]);
                rr_q[i] <= reset_rr_val(PTR_W'(i), rr_q[i]);
            end
            rx_q <= '0;
        end else begin
            if (reg_store) begin
                wr_q[ptr_q] <= wdata;
                if (ptr_q == IX_RXCFG && wdata[4]) begin
                    rr_q[IX_STAT][4] <= 1'b1;
                end
                if (ptr_q == IX_TCLO || ptr_q == IX_TCHI) begin
                    rr_q[ptr_q] <= wdata;
                end
            end
            if (data_wr) begin
                rr_q[IX_STAT][2] <= 1'b1;
                rr_q[IX_SENT][0] <= 1'b1;
            end
            if (data_rd) begin
                rr_q[IX_STAT][0] <= 1'b0;
            end else if (rx_push && wr_q[IX_RXCFG][0] && !rr_q[IX_STAT][0]) begin
                rx_q             <= rx_byte;
                rr_q[IX_STAT][0] <= 1'b1;
            end
        end
    end

    // strobe outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_fire <= 1'b0;
            tx_byte <= '0;
            rx_pop  <= 1'b0;
        end else begin
            tx_fire <= data_wr && wr_q[IX_TXCFG][3];
            rx_pop  <= data_rd;
            if (data_wr) begin
                tx_byte <= wdata;
            end
        end
    end

    assign rd_byte = is_data ? rx_q : rr_q[ptr_q];

    sreg_baud u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (tc_upd),
        .mode  (wr_q[IX_LINE][7:6]),
        .tc    ({wr_q[IX_TCHI], wr_q[IX_TCLO]}),
        .div   (div)
    );

    AST_READ_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> ptr_q == '0); // R4

    AST_ARMED_WRITE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && state_q == PS_ARMED && ptr_q != IX_RSTCTL) |=> ptr_q == '0); // R4

    AST_RESET_CMD_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ptr_q == IX_RSTCTL && wdata[7:6] != 2'b00 && !self_rst) |=> $stable(ptr_q)); // R5

    AST_RESET_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        self_rst |=> state_q == PS_BASE && ptr_q == '0); // R5

    AST_RESET_EXTEN: assert property (@(posedge clk) disable iff (!rst_n)
        self_rst |=> wr_q[IX_EXTEN] == 8'hF8); // R6

    AST_HARD_CLKSRC: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |=> wr_q[IX_CLKSRC] == 8'h08); // R7

    AST_DATA_WR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !self_rst) |=> rr_q[IX_STAT][2] && rr_q[IX_SENT][0]); // R9

    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |-> $past(wr_q[IX_TXCFG][3])); // R9

    AST_DATA_RD_CLEARS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> !rr_q[IX_STAT][0]); // R10

endmodule

// File: rtl/sreg_dual_regfile.sv
module sreg_dual_regfile
    import sreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     addr_swap,
    input  logic                     acc_wr,
    input  logic                     acc_rd,
    input  logic [1:0]               addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [NUM_CH-1:0]        rx_push,
    input  logic [NUM_CH*BYTE_W-1:0] rx_byte,
    output logic [NUM_CH-1:0]        tx_valid,
    output logic [BYTE_W-1:0]        tx_byte,
    output logic [NUM_CH-1:0]        rx_pop,
    output logic [NUM_CH*DIV_W-1:0]  baud_div
);

    logic              ch_sel;
    logic              is_data;
    rst_code_e         req [NUM_CH];
    logic [1:0]        any_req;
    logic [NUM_CH-1:0] soft_rst;
    logic              hard_rst;
    logic [BYTE_W-1:0] rd_byte [NUM_CH];
    logic [BYTE_W-1:0] ch_tx_byte [NUM_CH];

    sreg_decode u_decode (
        .addr_swap (addr_swap),
        .addr      (addr),
        .ch_sel    (ch_sel),
        .is_data   (is_data)
    );

    always_comb begin
        any_req = 2'b00;
        for (int c = 0; c < NUM_CH; c++) begin
            any_req = any_req | req[c];
        end
        hard_rst = (any_req == RST_BOTH);
        for (int c = 0; c < NUM_CH; c++) begin
            soft_rst[c] = (any_req == 2'(c + 1));
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sreg_chan #(.CH_ID(g)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (ch_sel == 1'(g)),
            .is_data  (is_data),
            .acc_wr   (acc_wr),
            .acc_rd   (acc_rd),
            .wdata    (wdata),
            .rx_push  (rx_push[g]),
            .rx_byte  (rx_byte[g*BYTE_W +: BYTE_W]),
            .soft_rst (soft_rst[g]),
            .hard_rst (hard_rst),
            .rst_req  (req[g]),
            .rd_byte  (rd_byte[g]),
            .tx_fire  (tx_valid[g]),
            .tx_byte  (ch_tx_byte[g]),
            .rx_pop   (rx_pop[g]),
            .div      (baud_div[g*DIV_W +: DIV_W])
        );
    end

    always_comb begin
        tx_byte = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (tx_valid[c]) begin
                tx_byte = ch_tx_byte[c];
            end
        end
    end

    assign rdata = acc_rd ? rd_byte[ch_sel] : '0;

    AST_TX_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_valid)); // R9

    AST_POP_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop)); // R10

    AST_RESET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({soft_rst, hard_rst}) <= 1); // R5

endmodule

// File: tb/sreg_dual_regfile_test.sv
module sreg_dual_regfile_test;
    import sreg_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     addr_swap = 1'b0;
    logic                     acc_wr = 1'b0;
    logic                     acc_rd = 1'b0;
    logic [1:0]               addr = '0;
    logic [BYTE_W-1:0]        wdata = '0;
    logic [BYTE_W-1:0]        rdata;
    logic [NUM_CH-1:0]        rx_push = '0;
    logic [NUM_CH*BYTE_W-1:0] rx_byte = '0;
    logic [NUM_CH-1:0]        tx_valid;
    logic [BYTE_W-1:0]        tx_byte;
    logic [NUM_CH-1:0]        rx_pop;
    logic [NUM_CH*DIV_W-1:0]  baud_div;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [9:0] exp_q [$];   // {is_pop, channel, byte}

    always #4 clk = ~clk;

    sreg_dual_regfile uut (
        .clk(clk), .rst_n(rst_n), .addr_swap(addr_swap), .acc_wr(acc_wr),
        .acc_rd(acc_rd), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .rx_pop(rx_pop), .baud_div(baud_div)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus(input bit w, input bit ch, input bit dat, input logic [7:0] v,
                       output logic [7:0] r);
        addr   = addr_swap ? {dat, ch} : {ch, dat};
        acc_wr = w;
        acc_rd = !w;
        wdata  = v;
        #1 r = rdata;
        @(negedge clk);
        acc_wr = 1'b0;
        acc_rd = 1'b0;
    endtask

    task automatic wreg(input bit ch, input int idx, input logic [7:0] v);
        logic [7:0] d;
        if (idx != 0) bus(1'b1, ch, 1'b0, (idx >= 8) ? 8'(8'h08 | (idx & 7)) : 8'(idx), d);
        bus(1'b1, ch, 1'b0, v, d);
    endtask

    task automatic rreg(input bit ch, input int idx, output logic [7:0] r);
        logic [7:0] d;
        if (idx != 0) bus(1'b1, ch, 1'b0, (idx >= 8) ? 8'(8'h08 | (idx & 7)) : 8'(idx), d);
        bus(1'b0, ch, 1'b0, 8'h00, r);
    endtask

    task automatic push(input bit ch, input logic [7:0] v);
        rx_push[ch] = 1'b1;
        rx_byte[ch*8 +: 8] = v;
        @(negedge clk);
        rx_push = '0;
    endtask

    function automatic logic [23:0] div_of(input bit ch);
        return baud_div[ch*DIV_W +: DIV_W];
    endfunction

    // monitor: compares strobes against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (tx_valid[c] || rx_pop[c]) begin
                    logic [9:0] got;
                    got = tx_valid[c] ? {1'b0, 1'(c), tx_byte} : {1'b1, 1'(c), 8'h00};
                    if (exp_q.size() == 0) begin
                        chk("R9/R10 unexpected strobe", {22'd0, got}, 32'h3FF);
                    end else begin
                        chk("R9/R10 strobe", {22'd0, got}, {22'd0, exp_q.pop_front()});
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 power-up values
        rreg(0, 0, r); chk("R1 ch0 status", r, 8'h04);
        rreg(1, 0, r); chk("R1 ch1 status", r, 8'h04);
        rreg(0, 1, r); chk("R1 ch0 sent", r, 8'h00);
        chk("R1 ch0 divisor", div_of(0), 24'd4);
        chk("R1 ch1 divisor", div_of(1), 24'd4);
        chk("R1 strobes idle", {tx_valid, rx_pop}, 4'b0);

        // R3 upper pointer, R8 mirror
        wreg(0, 12, 8'h34);
        rreg(0, 12, r); chk("R3/R8 ch0 tc low mirror", r, 8'h34);
        wreg(1, 13, 8'h56);
        rreg(1, 13, r); chk("R3/R8 ch1 tc high mirror", r, 8'h56);
        rreg(1, 12, r); chk("R3 ch1 tc low untouched", r, 8'h00);
        chk("R11 ch0 divisor x1", div_of(0), 24'd108);

        // R4 pointer returns after write and after read
        rreg(0, 0, r); chk("R4 pointer returned after write", r, 8'h04);
        bus(1'b1, 1'b0, 1'b0, 8'h0C, r);
        bus(1'b0, 1'b0, 1'b0, 8'h00, r); chk("R4 selected read", r, 8'h34);
        bus(1'b0, 1'b0, 1'b0, 8'h00, r); chk("R4 read cleared pointer", r, 8'h04);

        // R8 hunt bit
        wreg(0, 3, 8'h11);
        rreg(0, 0, r); chk("R8 hunt sets sync", r, 8'h14);

        // R10 receive path
        push(0, 8'hA5);
        rreg(0, 0, r); chk("R10 push sets avail", r, 8'h15);
        push(0, 8'h3C);
        exp_q.push_back({1'b1, 1'b0, 8'h00});
        bus(1'b0, 1'b0, 1'b1, 8'h00, r); chk("R10 first byte kept", r, 8'hA5);
        rreg(0, 0, r); chk("R10 read clears avail", r, 8'h14);
        push(1, 8'h99);
        rreg(1, 0, r); chk("R10 push refused when disabled", r, 8'h04);
        exp_q.push_back({1'b1, 1'b1, 8'h00});
        bus(1'b0, 1'b1, 1'b1, 8'h00, r); chk("R10 no byte latched", r, 8'h00);

        // R9 transmit path
        bus(1'b1, 1'b0, 1'b1, 8'h55, r);
        rreg(0, 1, r); chk("R9 all sent", r, 8'h01);
        rreg(0, 0, r); chk("R9 tx empty", r, 8'h14);
        wreg(0, 5, 8'h08);
        exp_q.push_back({1'b0, 1'b0, 8'h77});
        bus(1'b1, 1'b0, 1'b1, 8'h77, r);

        // R11 divisor timing
        wreg(0, 4, 8'h40);
        wreg(0, 12, 8'h0A);
        wreg(0, 13, 8'h01);
        chk("R11 divisor not yet updated", div_of(0), 24'd384);
        @(negedge clk);
        chk("R11 divisor x16", div_of(0), 24'd8576);

        // R2 strap swap
        addr_swap = 1'b1;
        wreg(1, 12, 8'hC3);
        rreg(1, 12, r); chk("R2 swapped access", r, 8'hC3);
        addr_swap = 1'b0;
        rreg(1, 12, r); chk("R2 same channel unswapped", r, 8'hC3);
        rreg(0, 12, r); chk("R2 other channel unswapped", r, 8'h0A);

        // R5/R6 soft reset of channel 1 issued from channel 0
        wreg(1, 3, 8'h11);
        push(1, 8'h42);
        rreg(1, 0, r); chk("R10 ch1 avail", r, 8'h15);
        wreg(1, 5, 8'h08);
        exp_q.push_back({1'b0, 1'b1, 8'hEE});
        bus(1'b1, 1'b1, 1'b1, 8'hEE, r);
        bus(1'b1, 1'b1, 1'b0, 8'h0D, r);
        wreg(0, 9, 8'h80);
        bus(1'b0, 1'b0, 1'b0, 8'h00, r); chk("R5 writer pointer held at 9", r, 8'h00);
        bus(1'b0, 1'b0, 1'b0, 8'h00, r); chk("R5 writer status intact", r, 8'h14);
        bus(1'b0, 1'b1, 1'b0, 8'h00, r); chk("R5/R6 reset pointer cleared, status mask", r, 8'h54);
        rreg(1, 1, r); chk("R6 sent mask", r, 8'h07);
        push(1, 8'h11);
        rreg(1, 0, r); chk("R6 receive enable dropped", r, 8'h54);
        bus(1'b1, 1'b1, 1'b1, 8'h33, r);
        chk("R6 divisor kept", div_of(1), 24'd44426);

        // R7 hard reset from channel 1
        wreg(1, 9, 8'hC0);
        bus(1'b0, 1'b1, 1'b0, 8'h00, r); chk("R7 ch1 status", r, 8'h54);
        bus(1'b0, 1'b0, 1'b0, 8'h00, r); chk("R7 ch0 status", r, 8'h54);
        rreg(0, 1, r); chk("R7 ch0 sent", r, 8'h07);
        rreg(0, 12, r); chk("R7 mirror kept", r, 8'h0A);
        bus(1'b1, 1'b0, 1'b1, 8'h21, r);
        chk("R7 divisor kept", div_of(0), 24'd8576);

        // R5 soft reset of channel 0 issued from channel 1
        wreg(0, 3, 8'h01);
        push(0, 8'h5A);
        rreg(0, 0, r); chk("R10 ch0 avail after reenable", r, 8'h55);
        wreg(1, 9, 8'h40);
        rreg(0, 0, r); chk("R5 ch0 soft reset", r, 8'h54);
        bus(1'b0, 1'b1, 1'b0, 8'h00, r); chk("R5 ch1 pointer held", r, 8'h00);

        // R11 prescaler modes
        wreg(0, 4, 8'hC0);
        chk("R11 x64 pending", div_of(0), 24'd8576);
        @(negedge clk);
        chk("R11 x64", div_of(0), 24'd34304);
        wreg(0, 4, 8'h80);
        @(negedge clk);
        chk("R11 x32", div_of(0), 24'd17152);

        repeat (3) @(negedge clk);
        chk("R9/R10 all strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule